// File: doc/BRIEF.md
# Serial Status Poll Shifter

This block is the device-side responder for the status-read command on a four-wire serial link in mode 0. The link carries chip select (active low), a serial clock and a data line from the host. SCK idles low; the device samples the host line on rising edges and drives the reply on falling edges. The block recognises the status-read opcode in the first byte of a frame. From the falling edge that follows that byte, it shifts out an 8-bit status byte, most significant bit first.

The byte repeats for as long as chip select stays low and SCK keeps running. A new snapshot of the status inputs is taken at the start of every byte, so a host can poll the ready flag without ending the frame. The status byte holds five fields:

- the live ready flag;
- a latched page-compare result, loaded by a pulse from the compare engine;
- a fixed density code;
- a protection flag;
- a page-size flag.

Frames that start with any other opcode get no reply. The output enable drops as soon as chip select rises.

The serial pins are brought into the block clock domain through a synchroniser of SYNC_STAGES flops (default 2). The status inputs are synchronous to `clk`.

Top module: `sts_poll_shifter`

## Requirements
- R1: While rst_n is low, and after its release with chip select high, spi_so_en is 0.
- R2: When spi_cs_n is 1, spi_so_en is 0 in that same cycle. Raising chip select mid-frame ends the frame, including a frame cut short inside the opcode byte. The next frame is decoded afresh from its first bit.
- R3: The first 8 bits of a frame are taken from spi_si on rising SCK edges, MSB first. If they form any value other than 0xD7, spi_so_en stays 0 for the rest of that frame.
- R4: After opcode 0xD7, output starts on the first falling SCK edge after the eighth rising edge, with no dummy bits. From then until chip select rises, spi_so_en is 1.
- R5: The status byte goes out MSB first, one bit per falling SCK edge. spi_so does not change in a cycle with no falling SCK edge.
- R6: The status byte is laid out as follows. Bit 7 is dev_ready (1 = ready, 0 = busy). Bit 6 is the latched compare result. Bits 5 down to 2 are the DENSITY_CODE parameter (default 4'b1011). Bit 1 is prot_on. Bit 0 is bin_page (1 = binary page size).
- R7: After every 8 bits the byte repeats. Each repeat carries a snapshot taken on the falling edge that drives its bit 7. Input changes after that edge do not alter the byte being shifted.
- R8: A pulse on cmp_done loads cmp_mismatch into the compare latch (1 = pages differ, 0 = match). The latch keeps its value until the next pulse and resets to 0.
- R9: A cmp_done pulse sampled on the same clk edge as the snapshot is included in that byte. With the default two stages, that is the third rising clk edge that sees the new low SCK level. A pulse one edge later first appears in the following byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous reset, active low |
| spi_cs_n | input | 1 | Chip select from host, active low |
| spi_sck | input | 1 | Serial clock from host, idles low |
| spi_si | input | 1 | Serial data from host |
| dev_ready | input | 1 | 1 when the device is idle |
| cmp_done | input | 1 | One-cycle pulse: compare result valid |
| cmp_mismatch | input | 1 | Compare result, 1 = mismatch |
| prot_on | input | 1 | Protection enabled flag |
| bin_page | input | 1 | Binary page-size mode flag |
| spi_so | output | 1 | Serial status data to host |
| spi_so_en | output | 1 | Output enable for spi_so; 0 means high impedance |

## Verification
Two events can land in the same block clock cycle: a compare result arriving from the compare engine, and the per-byte status snapshot. The bench provokes this by placing a single cmp_done pulse, carrying the inverse of the latched result, at each clk edge from one to six after SCK falls at the end of a byte. It then judges bit 6 of the next byte: it must show the new value when the pulse edge is at or before the snapshot edge, and the old value otherwise. The byte after that must show the new value in every case.

// File: rtl/sts_poll_pkg.sv
// Package: shared constants and types for the status poll shifter.
// Assumes an 8-bit status byte and a 4-bit density field.
package sts_poll_pkg;

    localparam int BYTE_W = 8;
    localparam int IDX_W  = $clog2(BYTE_W);
    localparam int DENS_W = 4;

    localparam logic [BYTE_W-1:0] OPC_STATUS = 8'hD7;

    // Frame phase of the command decoder.
    typedef enum logic [1:0] {
        PH_OPCODE = 2'd0,
        PH_STATUS = 2'd1,
        PH_IGNORE = 2'd2
    } phase_t;

    // Status byte layout, MSB first.
    typedef struct packed {
        logic              ready;
        logic              cmp_miss;
        logic [DENS_W-1:0] density;
        logic              prot;
        logic              bin_page;
    } sts_byte_t;

endpackage

// File: rtl/sts_sync.sv
// Module: multi-bit flop-chain synchroniser.
// Assumes each bit is an independent level signal. STAGES selects the chain
// length (1 gives a single register).
module sts_sync #(
    parameter int             W       = 3,
    parameter int             STAGES  = 2,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    generate
        if (STAGES <= 1) begin : g_single
            logic [W-1:0] stg_q;
            // Single capture register.
            always_ff @(posedge clk) begin
                if (!rst_n) stg_q <= RST_VAL;
                else        stg_q <= d;
            end
            assign q = stg_q;
        end else begin : g_chain
            localparam int CW = STAGES * W;
            logic [CW-1:0] chain_q;
            // Shift the sampled vector through STAGES registers.
            always_ff @(posedge clk) begin
                if (!rst_n) chain_q <= {STAGES{RST_VAL}};
                else        chain_q <= {chain_q[CW-W-1:0], d};
            end
            assign q = chain_q[CW-1 -: W];
        end
    endgenerate

endmodule

// File: rtl/sts_link_front.sv
// Module: serial link front end.
// Synchronises chip select, SCK and SI, and produces one-cycle rise and fall
// strobes of SCK. The strobes are masked while the synchronised chip select
// is high. Assumes SCK is slow against clk (each level lasts several clk cycles).
module sts_link_front #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic spi_cs_n,
    input  logic spi_sck,
    input  logic spi_si,
    output logic cs_idle,
    output logic sck_rise,
    output logic sck_fall,
    output logic si_s
);

    logic [2:0] pins_s;
    logic       sck_s;
    logic       sck_prev_q;

    sts_sync #(
        .W       (3),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (3'b100)
    ) sync_i (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({spi_cs_n, spi_sck, spi_si}),
        .q     (pins_s)
    );

    assign cs_idle = pins_s[2];
    assign sck_s   = pins_s[1];
    assign si_s    = pins_s[0];

    // Remember the previous synchronised SCK level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) sck_prev_q <= 1'b0;
        else        sck_prev_q <= sck_s;
    end

    // Edge strobes, only while selected.
    always_comb begin
        sck_rise = sck_s & ~sck_prev_q & ~cs_idle;
        sck_fall = ~sck_s & sck_prev_q & ~cs_idle;
    end

endmodule

// File: rtl/sts_cmd_decode.sv
// Module: opcode collector and frame phase tracker.
// Gathers the first byte of a frame MSB first on rising SCK strobes and decides
// whether the frame is a status read. Any other opcode parks the frame in an
// ignore phase until chip select rises.
module sts_cmd_decode
    import sts_poll_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cs_idle,
    input  logic sck_rise,
    input  logic si_s,
    output logic sts_sel
);

    phase_t             phase_q;
    logic [BYTE_W-2:0]  opc_q;
    logic [IDX_W-1:0]   cnt_q;
    logic [BYTE_W-1:0]  opc_full;

    assign opc_full = {opc_q, si_s};

    // Phase, opcode shifter and bit counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_OPCODE;
            opc_q   <= '0;
            cnt_q   <= '0;
        end else if (cs_idle) begin
            phase_q <= PH_OPCODE;
            cnt_q   <= '0;
        end else if (sck_rise && phase_q == PH_OPCODE) begin
            opc_q <= opc_full[BYTE_W-2:0];
            cnt_q <= cnt_q + 1'b1;
            if (cnt_q == IDX_W'(BYTE_W - 1)) begin
                phase_q <= (opc_full == OPC_STATUS) ? PH_STATUS : PH_IGNORE;
            end
        end
    end

    assign sts_sel = (phase_q == PH_STATUS);

endmodule

// File: rtl/sts_cmp_latch.sv
// Module: compare result holder.
// Loads cmp_mismatch on a cmp_done pulse. Also offers the value the latch will
// hold after this edge, so that a snapshot in the same cycle sees a result
// arriving in that cycle.
module sts_cmp_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic cmp_done,
    input  logic cmp_mismatch,
    output logic cmp_q,
    output logic cmp_nxt
);

    assign cmp_nxt = cmp_done ? cmp_mismatch : cmp_q;

    // Hold the most recent compare result.
    always_ff @(posedge clk) begin
        if (!rst_n) cmp_q <= 1'b0;
        else        cmp_q <= cmp_nxt;
    end

endmodule

// File: rtl/sts_byte_shifter.sv
// Module: status byte shifter.
// On each falling SCK strobe in the status phase, it either loads a fresh
// snapshot (bit index 0) or shifts left by one. The MSB of the register is the
// serial output. The live flag marks that the first bit has been driven.
module sts_byte_shifter
    import sts_poll_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_idle,
    input  logic              sts_sel,
    input  logic              sck_fall,
    input  logic [BYTE_W-1:0] snap,
    output logic              so,
    output logic              live,
    output logic [IDX_W-1:0]  bit_idx
);

    logic [BYTE_W-1:0] sh_q;
    logic [IDX_W-1:0]  idx_q;
    logic              live_q;

    // Bit position and live flag; cleared when the frame ends.
    always_ff @(posedge clk) begin
        if (!rst_n || cs_idle) begin
            idx_q  <= '0;
            live_q <= 1'b0;
        end else if (sts_sel && sck_fall) begin
            idx_q  <= idx_q + 1'b1;
            live_q <= 1'b1;
        end
    end

    // Data register: snapshot at byte start, shift otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_q <= '0;
        end else if (sts_sel && sck_fall) begin
            if (idx_q == '0) sh_q <= snap;
            else             sh_q <= {sh_q[BYTE_W-2:0], 1'b0};
        end
    end

    assign so      = sh_q[BYTE_W-1];
    assign live    = live_q;
    assign bit_idx = idx_q;

endmodule

// File: rtl/sts_poll_shifter.sv
// Module: continuously refreshed status register shifter (top).
// Answers opcode 0xD7 on a mode-0 serial link with a repeating status byte
// that is re-sampled at the start of each byte. Assumes the status inputs are
// synchronous to clk and that SCK is much slower than clk.
module sts_poll_shifter
    import sts_poll_pkg::*;
#(
    parameter int                SYNC_STAGES  = 2,
    parameter logic [DENS_W-1:0] DENSITY_CODE = 4'b1011
) (
    input  logic clk,
    input  logic rst_n,
    input  logic spi_cs_n,
    input  logic spi_sck,
    input  logic spi_si,
    input  logic dev_ready,
    input  logic cmp_done,
    input  logic cmp_mismatch,
    input  logic prot_on,
    input  logic bin_page,
    output logic spi_so,
    output logic spi_so_en
);

    logic             cs_idle;
    logic             sck_rise;
    logic             sck_fall;
    logic             si_s;
    logic             sts_sel;
    logic             cmp_q;
    logic             cmp_nxt;
    logic             so_live;
    logic [IDX_W-1:0] bit_idx;
    sts_byte_t        snap;

    sts_link_front #(
        .SYNC_STAGES (SYNC_STAGES)
    ) front_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .spi_cs_n (spi_cs_n),
        .spi_sck  (spi_sck),
        .spi_si   (spi_si),
        .cs_idle  (cs_idle),
        .sck_rise (sck_rise),
        .sck_fall (sck_fall),
        .si_s     (si_s)
    );

    sts_cmd_decode decode_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .cs_idle  (cs_idle),
        .sck_rise (sck_rise),
        .si_s     (si_s),
        .sts_sel  (sts_sel)
    );

    sts_cmp_latch cmp_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .cmp_done     (cmp_done),
        .cmp_mismatch (cmp_mismatch),
        .cmp_q        (cmp_q),
        .cmp_nxt      (cmp_nxt)
    );

    // Assemble the live status view sampled at each byte start.
    always_comb begin
        snap.ready    = dev_ready;
        snap.cmp_miss = cmp_nxt;
        snap.density  = DENSITY_CODE;
        snap.prot     = prot_on;
        snap.bin_page = bin_page;
    end

    sts_byte_shifter shifter_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .cs_idle  (cs_idle),
        .sts_sel  (sts_sel),
        .sck_fall (sck_fall),
        .snap     (snap),
        .so       (spi_so),
        .live     (so_live),
        .bit_idx  (bit_idx)
    );

    // Enable is gated by the raw pin so release is immediate.
    assign spi_so_en = so_live & ~spi_cs_n;

endmodule

// File: rtl/sts_poll_shifter_chk.sv
// Checker: temporal properties of the status poll shifter, bound to the top.
module sts_poll_shifter_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       spi_cs_n,
    input logic       spi_so,
    input logic       spi_so_en,
    input logic       dev_ready,
    input logic       cmp_done,
    input logic       cmp_mismatch,
    input logic       cmp_q,
    input logic       sck_fall,
    input logic       sts_sel,
    input logic [2:0] bit_idx
);

    a_r2_so_released: assert property (@(posedge clk) disable iff (!rst_n)
        spi_cs_n |-> !spi_so_en);

    a_r5_so_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(sck_fall && sts_sel) |=> $stable(spi_so));

    a_r7_fresh_ready: assert property (@(posedge clk) disable iff (!rst_n)
        (sck_fall && sts_sel && bit_idx == 3'd0) |=> (spi_so == $past(dev_ready)));

    a_r8_cmp_capture: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_done |=> (cmp_q == $past(cmp_mismatch)));

    a_r8_cmp_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !cmp_done |=> $stable(cmp_q));

endmodule

bind sts_poll_shifter sts_poll_shifter_chk chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .spi_cs_n     (spi_cs_n),
    .spi_so       (spi_so),
    .spi_so_en    (spi_so_en),
    .dev_ready    (dev_ready),
    .cmp_done     (cmp_done),
    .cmp_mismatch (cmp_mismatch),
    .cmp_q        (cmp_q),
    .sck_fall     (sck_fall),
    .sts_sel      (sts_sel),
    .bit_idx      (bit_idx)
);

// File: tb/sts_poll_shifter_tb_top.sv
// Bench: sweeps every opcode, all status-input combinations across a running
// frame, the compare/snapshot coincidence window, and frame aborts.
module sts_poll_shifter_tb_top;

    localparam int         HALF = 6;
    localparam int         SYNC = 2;
    localparam logic [3:0] DEN  = 4'b1011;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic rst_n, cs_n, sck, si, rdy, cdone, cmis, prot, binp;
    logic so, so_en;
    logic cmp_model;
    int   checks = 0;
    int   fails  = 0;

    sts_poll_shifter #(
        .SYNC_STAGES  (SYNC),
        .DENSITY_CODE (DEN)
    ) dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .spi_cs_n     (cs_n),
        .spi_sck      (sck),
        .spi_si       (si),
        .dev_ready    (rdy),
        .cmp_done     (cdone),
        .cmp_mismatch (cmis),
        .prot_on      (prot),
        .bin_page     (binp),
        .spi_so       (so),
        .spi_so_en    (so_en)
    );

    function automatic logic [7:0] exp_byte(input logic r, input logic m,
                                            input logic p, input logic b);
        return {r, m, DEN, p, b};
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic do_bit(input logic mo, output logic s_so, output logic s_en);
        si = mo;
        repeat (HALF) @(negedge clk);
        s_so = so;
        s_en = so_en;
        sck = 1'b1;
        repeat (HALF) @(negedge clk);
        sck = 1'b0;
    endtask

    // One byte; optionally applies the next status inputs after bit 7.
    task automatic do_byte(input logic [7:0] mo, input bit apply,
                           input logic [3:0] nxt,
                           output logic [7:0] got, output logic [7:0] ens);
        for (int i = 7; i >= 0; i--) begin
            do_bit(mo[i], got[i], ens[i]);
            if (i == 7 && apply) begin
                rdy = nxt[3]; prot = nxt[1]; binp = nxt[0];
                cdone = 1'b1; cmis = nxt[2];
                @(negedge clk);
                cdone = 1'b0; cmp_model = nxt[2];
            end
        end
    endtask

    task automatic frame_start();
        cs_n = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic frame_end();
        cs_n = 1'b1;
        repeat (HALF) @(negedge clk);
    endtask

    task automatic set_status(input logic [3:0] v);
        rdy = v[3]; prot = v[1]; binp = v[0];
        cdone = 1'b1; cmis = v[2];
        @(negedge clk);
        cdone = 1'b0; cmp_model = v[2];
    endtask

    initial begin : watchdog
        repeat (180000) @(posedge clk);
        fails++;
        $display("FAIL watchdog run did not finish actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin : main
        logic [7:0] got, ens;
        logic       b_so, b_en;
        cs_n = 1'b1; sck = 1'b0; si = 1'b0; rdy = 1'b1; cdone = 1'b0;
        cmis = 1'b0; prot = 1'b0; binp = 1'b0; cmp_model = 1'b0; rst_n = 1'b0;
        repeat (4) @(negedge clk);
        chk(so_en == 1'b0, "R1", "enable in reset", so_en, 0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        chk(so_en == 1'b0, "R1", "enable after reset", so_en, 0);

        // R3/R4/R6: every opcode, then one reply byte.
        for (int op = 0; op < 256; op++) begin
            frame_start();
            do_byte(op[7:0], 1'b0, 4'h0, got, ens);
            chk(ens == 8'h00, "R3", "enable during opcode", ens, 0);
            do_byte(8'h00, 1'b0, 4'h0, got, ens);
            if (op == 8'hD7) begin
                chk(ens == 8'hFF, "R4", "enable after status opcode", ens, 8'hFF);
                chk(got == exp_byte(1'b1, 1'b0, 1'b0, 1'b0), "R6", "first byte",
                    got, exp_byte(1'b1, 1'b0, 1'b0, 1'b0));
            end else begin
                chk(ens == 8'h00, "R3", "enable after other opcode", ens, 0);
            end
            frame_end();
        end

        // R6/R7/R8: all input combinations in one running frame.
        set_status(4'h0);
        frame_start();
        do_byte(8'hD7, 1'b0, 4'h0, got, ens);
        for (int c = 0; c < 16; c++) begin
            logic [3:0] cv;
            cv = c[3:0];
            do_byte(8'h00, 1'b1, cv + 4'h1, got, ens);
            chk(got == exp_byte(cv[3], cv[2], cv[1], cv[0]), "R7",
                "repeated fresh byte", got, exp_byte(cv[3], cv[2], cv[1], cv[0]));
            chk(ens == 8'hFF, "R4", "enable while polling", ens, 8'hFF);
        end
        frame_end();

        // R9: compare pulse placed k clk edges after the byte-start fall.
        for (int k = 1; k <= 6; k++) begin
            logic old_v, new_v, exp6;
            set_status(4'b1001);
            old_v = cmp_model;
            new_v = ~old_v;
            frame_start();
            do_byte(8'hD7, 1'b0, 4'h0, got, ens);
            for (int i = 7; i >= 1; i--) do_bit(1'b0, got[i], ens[i]);
            si = 1'b0;
            repeat (HALF) @(negedge clk);
            got[0] = so;
            sck = 1'b1;
            repeat (HALF) @(negedge clk);
            sck = 1'b0;
            repeat (k - 1) @(negedge clk);
            cdone = 1'b1; cmis = new_v;
            @(negedge clk);
            cdone = 1'b0; cmp_model = new_v;
            repeat (HALF - k) @(negedge clk);
            chk(got == exp_byte(1'b1, old_v, 1'b0, 1'b1), "R8", "byte before pulse",
                got, exp_byte(1'b1, old_v, 1'b0, 1'b1));
            exp6 = (k <= SYNC + 1) ? new_v : old_v;
            do_byte(8'h00, 1'b0, 4'h0, got, ens);
            chk(got[6] == exp6, "R9", $sformatf("coincident compare k=%0d", k),
                got[6], exp6);
            do_byte(8'h00, 1'b0, 4'h0, got, ens);
            chk(got[6] == new_v, "R8", "latched compare persists", got[6], new_v);
            frame_end();
        end

        // R2: abort mid status byte, then mid opcode, then a clean frame.
        set_status(4'b1010);
        frame_start();
        do_byte(8'hD7, 1'b0, 4'h0, got, ens);
        for (int i = 0; i < 3; i++) do_bit(1'b0, b_so, b_en);
        chk(so_en == 1'b1, "R4", "enable before abort", so_en, 1);
        cs_n = 1'b1;
        #1;
        chk(so_en == 1'b0, "R2", "enable at chip select rise", so_en, 0);
        repeat (HALF) @(negedge clk);
        frame_start();
        for (int i = 7; i >= 4; i--) do_bit(((8'hD7 >> i) & 8'h01) != 0, b_so, b_en);
        frame_end();
        frame_start();
        do_byte(8'hD7, 1'b0, 4'h0, got, ens);
        do_byte(8'h00, 1'b0, 4'h0, got, ens);
        chk(ens == 8'hFF, "R2", "enable in fresh frame", ens, 8'hFF);
        chk(got == exp_byte(1'b1, 1'b0, 1'b1, 1'b0), "R2", "byte in fresh frame",
            got, exp_byte(1'b1, 1'b0, 1'b1, 1'b0));
        frame_end();
        chk(so_en == 1'b0, "R2", "enable after frame", so_en, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule